// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Write Port

This block holds a 256-entry table of 24-bit colours. A pixel pipeline reads it through a purely combinational port: it presents an 8-bit pixel code and gets the matching red, green and blue bytes back in the same cycle. Software reaches the table through a small 32-bit register window with two live registers. The pointer register selects an entry. The colour register is written three times in a row, once for each component.

A hidden phase counter decides which component each colour write lands in. After the third component the pointer steps to the next entry, so a whole table can be loaded with one pointer write followed by a stream of colour writes. Only the top byte of each bus word carries data. Reads from the window always return zero. Reset leaves every entry black except the last one, which is white.

Top module: `clut_dac`

## Requirements
- R1: A write at byte offset 0 loads the entry pointer from bus bits 31:24 and returns the component phase to red.
- R2: Successive writes at byte offset 4 store bus bits 31:24 into the red, green and blue components of the pointed entry, in that order; the lookup output is {red[23:16], green[15:8], blue[7:0]}.
- R3: The blue write advances the pointer by one modulo 256 (255 wraps to 0) and returns the phase to red.
- R4: A pointer write in the middle of a triple restarts the sequence at red and leaves the components already written untouched.
- R5: A write at any window offset other than 0 and 4 changes neither the table, the pointer nor the phase.
- R6: Bus bits 23:0 of every write are ignored.
- R7: After reset, entries 0 to 254 read 0x000000, entry 255 reads 0xFFFFFF, the pointer is 0 and the phase is red.
- R8: The lookup port is combinational. A write shows on it from the cycle after the write strobe, and a lookup of the entry being written in the same cycle returns the old value.
- R9: The bus read data output is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Single-cycle write strobe |
| wr_addr | input | 4 | Byte offset within the register window |
| wr_data | input | 32 | Bus write word; only bits 31:24 are used |
| bus_rd_data | output | 32 | Read data for the register window, always zero |
| lk_index | input | 8 | Pixel code to look up |
| lk_color | output | 24 | Colour of the addressed entry {R,G,B} |

## Verification
On every cycle the assertions check the pointer and phase state machine: a pointer load, the phase stepping red, green, blue, the advance with wrap on blue, and both held still when no decoded write arrives. They also check that a component written in one cycle is stored in the next. The ordering of the components on the lookup output, the reset contents of all 256 entries, the old value returned for a lookup that coincides with a write, and the fact that a stray offset leaves the table alone can only be shown by the bench. It does this by comparing the lookup port against its own model of the table after directed and random write streams.

// File: rtl/clut_pkg.sv
// Package: shared types for the colour lookup table.
// Assumes three colour components, stepped in a fixed red, green, blue order.
package clut_pkg;
    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    localparam int NUM_COMP = 3;
endpackage

// File: rtl/clut_decode.sv
// Module: clut_decode
// Turns a strobed bus write into a pointer load or a colour load and
// extracts the data byte from the top of the bus word.
// Assumes a single-cycle strobe and a byte offset within the window.
module clut_decode #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int CH_W      = 8,
    parameter int OFF_INDEX = 0,
    parameter int OFF_DATA  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              idx_load,
    output logic              dat_load,
    output logic [CH_W-1:0]   wr_byte
);
    localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(OFF_INDEX);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);

    // Full-offset compare: only the two live registers respond.
    always_comb begin
        idx_load = wr_valid && (wr_addr == A_INDEX);
        dat_load = wr_valid && (wr_addr == A_DATA);
    end

    // Data byte comes from the most significant byte of the word.
    assign wr_byte = wr_data[DATA_W-1 -: CH_W];

    // R6: a strobed word must be fully driven, even though its low bits are dropped.
    p_known_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$isunknown(wr_data));

    // R5: the two loads are never raised together.
    p_single_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_load && dat_load));
endmodule

// File: rtl/clut_phase_seq.sv
// Module: clut_phase_seq
// Holds the entry pointer and the component phase. Colour loads step the
// phase red, green, blue; after blue the pointer advances with wrap.
// Assumes at most one of idx_load and dat_load is high per cycle.
module clut_phase_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idx_load,
    input  logic                dat_load,
    input  logic [CH_W-1:0]     wr_byte,
    output logic                mem_we,
    output logic [IDX_W-1:0]    mem_addr,
    output logic [NUM_COMP-1:0] mem_comp,
    output logic [CH_W-1:0]     mem_byte
);
    logic [IDX_W-1:0] idx_q;
    phase_e           phase_q;

    // Pointer and phase update on pointer loads and colour loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            phase_q <= PH_RED;
        end else if (idx_load) begin
            idx_q   <= wr_byte[IDX_W-1:0];
            phase_q <= PH_RED;
        end else if (dat_load) begin
            unique case (phase_q)
                PH_RED:   phase_q <= PH_GREEN;
                PH_GREEN: phase_q <= PH_BLUE;
                PH_BLUE: begin
                    phase_q <= PH_RED;
                    idx_q   <= idx_q + 1'b1;
                end
                default:  phase_q <= PH_RED;
            endcase
        end
    end

    // Component select: bit 2 red, bit 1 green, bit 0 blue.
    always_comb begin
        unique case (phase_q)
            PH_GREEN: mem_comp = 3'b010;
            PH_BLUE:  mem_comp = 3'b001;
            default:  mem_comp = 3'b100;
        endcase
    end

    assign mem_we   = dat_load;
    assign mem_addr = idx_q;
    assign mem_byte = wr_byte;

    // R1: a pointer load takes the byte and restarts at red.
    p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_load |=> (idx_q == $past(wr_byte[IDX_W-1:0])) && (phase_q == PH_RED));

    // R2: red and green loads step the phase and keep the pointer.
    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_load && phase_q != PH_BLUE) |=>
            (phase_q == phase_e'($past(phase_q) + 2'd1)) && $stable(idx_q));

    // R3: a blue load advances the pointer modulo its width and restarts at red.
    p_blue_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_load && phase_q == PH_BLUE) |=>
            (idx_q == $past(idx_q) + 1'b1) && (phase_q == PH_RED));

    // R5: with no decoded write, the pointer and phase hold.
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_load && !dat_load) |=> $stable(idx_q) && $stable(phase_q));

    // R2: the phase never takes the unused encoding.
    p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != phase_e'(2'd3));
endmodule

// File: rtl/clut_store.sv
// Module: clut_store
// Register-based colour table with per-component write and a combinational
// lookup port. Reset makes every entry black except the last, which is white.
// Assumes one component write per cycle, selected by a one-hot mask.
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      waddr,
    input  logic [NUM_COMP-1:0]   wcomp,
    input  logic [CH_W-1:0]       wbyte,
    input  logic [IDX_W-1:0]      raddr,
    output logic [NUM_COMP*CH_W-1:0] rcolor
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int COLOR_W = NUM_COMP * CH_W;

    logic [COLOR_W-1:0] mem [ENTRIES];

    // Reset colour of one entry: white for the last, black for the rest.
    function automatic logic [COLOR_W-1:0] reset_colour(input int e);
        return (e == ENTRIES - 1) ? {COLOR_W{1'b1}} : {COLOR_W{1'b0}};
    endfunction

    // Table load on reset, component update on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                mem[e] <= reset_colour(e);
            end
        end else if (we) begin
            for (int c = 0; c < NUM_COMP; c++) begin
                if (wcomp[c]) begin
                    mem[waddr][c*CH_W +: CH_W] <= wbyte;
                end
            end
        end
    end

    // Lookup reads the registered table, so a same-cycle write is not seen.
    assign rcolor = mem[raddr];

    // R2: a write selects exactly one component.
    p_one_comp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ($countones(wcomp) == 1));

    generate
        for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp_chk
            // R8: a component written in one cycle is held from the next.
            p_comp_stored_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (we && wcomp[c]) |=>
                    (mem[$past(waddr)][c*CH_W +: CH_W] == $past(wbyte)));
        end
    endgenerate
endmodule

// File: rtl/clut_dac.sv
// Module: clut_dac (top)
// Memory-mapped colour lookup table: register window decode, component
// sequencer and colour store, with a combinational lookup port.
// Assumes single-cycle write strobes; window reads return zero.
module clut_dac #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 8,
    parameter int CH_W      = 8,
    parameter int OFF_INDEX = 0,
    parameter int OFF_DATA  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   bus_rd_data,
    input  logic [IDX_W-1:0]    lk_index,
    output logic [3*CH_W-1:0]   lk_color
);
    import clut_pkg::*;

    logic                idx_load;
    logic                dat_load;
    logic [CH_W-1:0]     wr_byte;
    logic                mem_we;
    logic [IDX_W-1:0]    mem_addr;
    logic [NUM_COMP-1:0] mem_comp;
    logic [CH_W-1:0]     mem_byte;

    clut_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W),
        .OFF_INDEX(OFF_INDEX), .OFF_DATA(OFF_DATA)
    ) u_decode (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .idx_load(idx_load), .dat_load(dat_load), .wr_byte(wr_byte)
    );

    clut_phase_seq #(.IDX_W(IDX_W), .CH_W(CH_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .idx_load(idx_load), .dat_load(dat_load), .wr_byte(wr_byte),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_comp(mem_comp),
        .mem_byte(mem_byte)
    );

    clut_store #(.IDX_W(IDX_W), .CH_W(CH_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_addr), .wcomp(mem_comp), .wbyte(mem_byte),
        .raddr(lk_index), .rcolor(lk_color)
    );

    // Window reads carry no state back to the bus.
    assign bus_rd_data = '0;
endmodule

// File: tb/sim_clut_dac.sv
module sim_clut_dac;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] bus_rd_data;
    logic [7:0]  lk_index = '0;
    logic [23:0] lk_color;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [23:0] m [256];
    logic [7:0]  mi;
    int          mp;

    clut_dac u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .bus_rd_data(bus_rd_data),
        .lk_index(lk_index), .lk_color(lk_color)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e < 256; e++) m[e] = (e == 255) ? 24'hFFFFFF : 24'h0;
        mi = 0;
        mp = 0;
    endtask

    // Bench model of one bus write.
    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        if (a == 4'd0) begin
            mi = d[31:24];
            mp = 0;
        end else if (a == 4'd4) begin
            m[mi][(2-mp)*8 +: 8] = d[31:24];
            if (mp == 2) begin
                mi = mi + 8'd1;
                mp = 0;
            end else begin
                mp++;
            end
        end
    endtask

    // One strobed write; checks the old value during the strobe and the new after.
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input string req);
        logic [7:0] tgt;
        @(negedge clk);
        tgt = mi;
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        lk_index = tgt;
        #1;
        chk({8'h0, lk_color}, {8'h0, m[tgt]}, "R8 same-cycle old value");
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        model_write(a, d);
        #1;
        chk({8'h0, lk_color}, {8'h0, m[tgt]}, req);
    endtask

    task automatic look(input logic [7:0] e, input string req);
        lk_index = e;
        #1;
        chk({8'h0, lk_color}, {8'h0, m[e]}, req);
    endtask

    task automatic sweep(input string req);
        @(negedge clk);
        for (int e = 0; e < 256; e++) look(e[7:0], req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset contents; R9: reads return zero.
        sweep("R7 reset contents");
        chk(bus_rd_data, 32'h0, "R9 read data zero");
        // R7: pointer 0 and phase red after reset.
        bus_write(4'd4, 32'h12_000000, "R7 first data lands in entry 0 red");
        chk({8'h0, m[0]}, 32'h00120000, "R7 model entry 0");
        look(8'd0, "R7 entry 0 red");

        // R2 and R3: triples through the wrap point.
        bus_write(4'd0, 32'hFE_000000, "R1 pointer load");
        for (int t = 0; t < 3; t++) begin
            bus_write(4'd4, {8'(8'h30 + t*16 + 1), 24'h0}, "R2 red");
            bus_write(4'd4, {8'(8'h30 + t*16 + 2), 24'h0}, "R2 green");
            bus_write(4'd4, {8'(8'h30 + t*16 + 3), 24'h0}, "R3 blue advance");
        end
        look(8'hFE, "R2 entry FE order");
        look(8'hFF, "R3 entry FF");
        look(8'h00, "R3 wrap to entry 0");
        chk({24'h0, mi}, 32'h1, "R3 model pointer wrapped");

        // R4: pointer write mid-triple restarts at red.
        bus_write(4'd0, 32'h40_000000, "R1 pointer load");
        bus_write(4'd4, 32'hA1_000000, "R2 red");
        bus_write(4'd4, 32'hA2_000000, "R2 green");
        bus_write(4'd0, 32'h40_000000, "R4 reload pointer");
        bus_write(4'd4, 32'hB1_000000, "R4 restart at red");
        look(8'h40, "R4 green kept, red replaced");

        // R5: stray offsets leave table and sequence alone.
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 4) bus_write(4'(a), 32'hEE_EEEEEE, "R5 stray offset");
        end
        sweep("R5 table unchanged");
        bus_write(4'd4, 32'hC2_000000, "R5 sequence resumes at green");
        look(8'h40, "R5 entry 40 green");

        // R6: low bits ignored for both registers.
        bus_write(4'd0, 32'h80_FFFFFF, "R6 pointer from top byte");
        bus_write(4'd4, 32'h01_ABCDEF, "R6 red top byte only");
        bus_write(4'd4, 32'h02_123456, "R6 green top byte only");
        bus_write(4'd4, 32'h03_FFFFFF, "R6 blue top byte only");
        look(8'h80, "R6 entry 80");

        // Random stream mixing offsets, with periodic lookups.
        for (int n = 0; n < 3000; n++) begin
            logic [3:0]  a;
            logic [31:0] d;
            int          r;
            r = $urandom_range(0, 9);
            a = (r < 1) ? 4'd0 : (r < 8) ? 4'd4 : 4'($urandom_range(0, 15));
            d = $urandom();
            bus_write(a, d, "R2 random write");
            if (n % 50 == 0) look(8'($urandom_range(0, 255)), "R8 random lookup");
        end
        sweep("R2 final table");
        chk(bus_rd_data, 32'h0, "R9 read data zero after traffic");

        // R7: reset again restores the table.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        sweep("R7 second reset contents");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule